// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block is a register-mapped master for the two-wire PHY management bus (MDC clock and bidirectional MDIO data, clause 22 framing). Software selects an MDC divider code, programs a combined PHY/register address, and then launches a transaction. A read is launched by a rising edge of the read command bit. A write is launched as a side effect of writing the 16-bit write-data register. The block serializes a 64-bit frame, releases the data line for read turnaround and data, and stores the 16 received bits for software.

A single indicator register reports both progress (busy) and whether the read status register holds fresh data (invalid). A soft-reset bit in the configuration register aborts any frame in progress. MDC is held low whenever no frame is active. The data pin is split into output, output enable and input, so that pad logic can build the tri-state buffer.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, the indicator reads 0x4 (busy=0, invalid=1), the command register reads 0, the divider code reads the DIV_RESET parameter (4), the read status reads 0, and MDC and the output enable are low.
- R2: Offset 0x28 reads back the PHY address in bits 12:8 and the register number in bits 4:0, with all other bits zero. Offset 0x20 reads back the divider code in bits 3:0, and bit 31 always reads 0.
- R3: A read starts only when a write to offset 0x24 changes bit 0 from 0 to 1 while idle. Writing 1 while the bit already holds 1 starts nothing.
- R4: Writing offset 0x2c while idle starts a write frame. It is sent MSB first as 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data bits. Each bit changes while MDC is low.
- R5: With divider code c, MDC is low for c+1 system clocks and then high for c+1 clocks per bit. MDC is low whenever no frame is active. The code is captured at frame start.
- R6: A read frame uses opcode 10. The output enable is low for the two turnaround bits and the 16 data bits. MDIO is sampled on each rising MDC edge during data, MSB first. The result appears in bits 15:0 of offset 0x30 when the frame ends.
- R7: Indicator bit 0 (busy) is 1 from the clock after launch for exactly 64 MDC periods, and clears on the final falling MDC edge.
- R8: Indicator bit 2 (invalid) is set by a read launch and by soft reset, and cleared when a read frame completes.
- R9: Writes to offset 0x2c and rising command edges while busy launch nothing. An ignored data write leaves the 0x2c readback unchanged.
- R10: Writing offset 0x20 with bit 31 set aborts any frame on the next clock. Busy clears, MDC and the output enable go low, the command bit clears and invalid sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit index or divider count shows at once on the pins: MDC edges or data bits move by one or more system clocks, and a per-clock comparison catches this within one MDC half-period. A corrupted receive shift register stays hidden until the frame ends, and then shows as a wrong value at offset 0x30. A busy or invalid flag that is stuck or late shows in the indicator register on the exact clock where the model expects it to change. A missed abort shows as MDC still toggling one clock after the soft-reset write.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PRE_LEN   = 32;
  localparam int PHY_W     = 5;
  localparam int REGN_W    = 5;
  localparam int DATA_W    = 16;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_W + REGN_W + 2 + DATA_W;
  localparam int RX_FIRST  = FRAME_LEN - DATA_W;
  localparam int TA_FIRST  = RX_FIRST - 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  localparam logic [7:0] OFS_CFG  = 8'h20;
  localparam logic [7:0] OFS_CMD  = 8'h24;
  localparam logic [7:0] OFS_ADR  = 8'h28;
  localparam logic [7:0] OFS_WDAT = 8'h2c;
  localparam logic [7:0] OFS_STAT = 8'h30;
  localparam logic [7:0] OFS_IND  = 8'h34;

  typedef logic [FRAME_LEN-1:0] frame_t;

  // Half period of MDC in system clocks for a divider code.
  function automatic int unsigned mdc_half(input logic [7:0] code);
    return int'(code) + 1;
  endfunction

  // Frame image, bit FRAME_LEN-1 goes out first.
  function automatic frame_t build_frame(input logic is_rd,
                                         input logic [PHY_W-1:0] phy,
                                         input logic [REGN_W-1:0] rn,
                                         input logic [DATA_W-1:0] d);
    logic [1:0] op, ta;
    logic [DATA_W-1:0] pay;
    op  = is_rd ? 2'b10 : 2'b01;
    ta  = is_rd ? 2'b11 : 2'b10;
    pay = is_rd ? '1 : d;
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, rn, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [DIV_W-1:0] code,
  input  logic             run,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  import mdio_mgmt_pkg::*;

  logic [DIV_W-1:0] half_m1_q;
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap     = run && (cnt_q == half_m1_q);
  assign rise_evt = wrap && !mdc_q;
  assign fall_evt = wrap && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_m1_q <= '0;
      cnt_q     <= '0;
      mdc_q     <= 1'b0;
    end else if (clr || load) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
      if (load) half_m1_q <= DIV_W'(mdc_half(8'(code)) - 1);
    end else if (run) begin
      if (wrap) begin
        cnt_q <= '0;
        mdc_q <= ~mdc_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_mgmt_shifter.sv
module mdio_mgmt_shifter (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         start_rd,
  input  mdio_mgmt_pkg::frame_t        frame_in,
  input  logic                         abort,
  input  logic                         rise_evt,
  input  logic                         fall_evt,
  input  logic                         mdio_i,
  output logic                         busy,
  output logic                         done,
  output logic                         rd_done,
  output logic [mdio_mgmt_pkg::DATA_W-1:0] rx_data,
  output logic                         mdio_o,
  output logic                         mdio_oe
);
  import mdio_mgmt_pkg::*;

  frame_t            frame_q;
  logic [IDX_W-1:0]  bit_idx;
  logic              busy_q;
  logic              is_rd_q;
  logic [DATA_W-1:0] rx_q;
  logic              last_bit;
  logic              in_rx;

  assign last_bit = (bit_idx == IDX_W'(FRAME_LEN - 1));
  assign in_rx    = is_rd_q && (bit_idx >= IDX_W'(RX_FIRST));
  assign done     = fall_evt && last_bit;
  assign rd_done  = done && is_rd_q;
  assign busy     = busy_q;
  assign rx_data  = rx_q;
  assign mdio_o   = frame_q[FRAME_LEN-1];
  assign mdio_oe  = busy_q && !(is_rd_q && bit_idx >= IDX_W'(TA_FIRST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      bit_idx <= '0;
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      rx_q    <= '0;
    end else if (abort) begin
      busy_q  <= 1'b0;
      bit_idx <= '0;
    end else if (start) begin
      frame_q <= frame_in;
      bit_idx <= '0;
      busy_q  <= 1'b1;
      is_rd_q <= start_rd;
      rx_q    <= '0;
    end else if (busy_q) begin
      if (rise_evt && in_rx) rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      if (fall_evt) begin
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          frame_q <= frame_q << 1;
        end
      end
    end
  end

  // R4
  start_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bit_idx == IDX_W'(PRE_LEN)) |-> !mdio_o);
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs #(
  parameter int ADDR_W    = 8,
  parameter int DIV_W     = 4,
  parameter int DIV_RESET = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 reg_wr,
  input  logic [ADDR_W-1:0]                    reg_addr,
  input  logic [31:0]                          reg_wdata,
  output logic [31:0]                          reg_rdata,
  input  logic                                 busy,
  input  logic                                 rd_done,
  input  logic [mdio_mgmt_pkg::DATA_W-1:0]     rx_data,
  output logic                                 start,
  output logic                                 start_rd,
  output logic                                 soft_rst,
  output mdio_mgmt_pkg::frame_t                frame,
  output logic [DIV_W-1:0]                     div_code
);
  import mdio_mgmt_pkg::*;

  logic              cmd_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REGN_W-1:0] rn_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] stat_q;
  logic              inv_q;
  logic [DIV_W-1:0]  code_q;
  logic wr_cfg, wr_cmd, wr_adr, wr_wdat, rd_go, wr_go;

  assign wr_cfg  = reg_wr && (reg_addr == ADDR_W'(OFS_CFG));
  assign wr_cmd  = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
  assign wr_adr  = reg_wr && (reg_addr == ADDR_W'(OFS_ADR));
  assign wr_wdat = reg_wr && (reg_addr == ADDR_W'(OFS_WDAT));

  assign soft_rst = wr_cfg && reg_wdata[31];
  assign rd_go    = wr_cmd && reg_wdata[0] && !cmd_q && !busy;
  assign wr_go    = wr_wdat && !busy;
  assign start    = rd_go || wr_go;
  assign start_rd = rd_go;
  assign div_code = code_q;
  assign frame    = build_frame(rd_go, phy_q, rn_q, reg_wdata[DATA_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      phy_q  <= '0;
      rn_q   <= '0;
      wdat_q <= '0;
      stat_q <= '0;
      inv_q  <= 1'b1;
      code_q <= DIV_W'(DIV_RESET);
    end else begin
      if (wr_cfg) code_q <= reg_wdata[DIV_W-1:0];
      if (soft_rst)    cmd_q <= 1'b0;
      else if (wr_cmd) cmd_q <= reg_wdata[0];
      if (wr_adr) begin
        phy_q <= reg_wdata[8 +: PHY_W];
        rn_q  <= reg_wdata[REGN_W-1:0];
      end
      if (wr_go) wdat_q <= reg_wdata[DATA_W-1:0];
      if (rd_done) stat_q <= rx_data;
      if (soft_rst || rd_go) inv_q <= 1'b1;
      else if (rd_done)      inv_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_CFG):  reg_rdata[DIV_W-1:0] = code_q;
      ADDR_W'(OFS_CMD):  reg_rdata[0] = cmd_q;
      ADDR_W'(OFS_ADR):  reg_rdata = {19'd0, phy_q, 3'd0, rn_q};
      ADDR_W'(OFS_WDAT): reg_rdata[DATA_W-1:0] = wdat_q;
      ADDR_W'(OFS_STAT): reg_rdata[DATA_W-1:0] = stat_q;
      ADDR_W'(OFS_IND):  reg_rdata = {29'd0, inv_q, 1'b0, busy};
      default:           reg_rdata = '0;
    endcase
  end

  // R8
  inv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> (inv_q && busy));
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt #(
  parameter int ADDR_W    = 8,
  parameter int DIV_W     = 4,
  parameter int DIV_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  import mdio_mgmt_pkg::*;

  logic              start, start_rd, soft_rst;
  logic              busy, done, rd_done;
  logic              rise_evt, fall_evt;
  logic [DIV_W-1:0]  div_code;
  logic [DATA_W-1:0] rx_data;
  frame_t            frame;

  mdio_mgmt_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .rd_done(rd_done), .rx_data(rx_data), .start(start), .start_rd(start_rd),
    .soft_rst(soft_rst), .frame(frame), .div_code(div_code)
  );

  mdio_mgmt_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .load(start), .code(div_code),
    .run(busy), .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_mgmt_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
    .frame_in(frame), .abort(soft_rst), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .mdio_i(mdio_i), .busy(busy), .done(done),
    .rd_done(rd_done), .rx_data(rx_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // R5
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !mdc && !mdio_oe));

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !mdc));

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fall_evt && busy && mdc));

  // R6
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done) |-> !mdio_oe);
endmodule

// File: tb/test_mdio_mgmt.sv
module test_mdio_mgmt;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int vectors = 0;
  int miscompares = 0;

  // behavioural reference state
  bit   m_act, m_rd, m_cmd, m_inv;
  int   m_k, m_h, m_code;
  logic [15:0] m_stat, m_rcv, phy_word;
  logic [4:0]  m_phy, m_rn;
  bit   fr[$];

  always #5 clk = ~clk;

  mdio_mgmt i_mdio_mgmt (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic launch(input bit rd, input logic [15:0] d);
    m_act = 1; m_k = 0; m_rd = rd; m_h = m_code + 1;
    fr.delete();
    for (int i = 0; i < 32; i++) fr.push_back(1'b1);
    fr.push_back(1'b0); fr.push_back(1'b1);
    fr.push_back(rd ? 1'b1 : 1'b0); fr.push_back(rd ? 1'b0 : 1'b1);
    for (int i = 4; i >= 0; i--) fr.push_back(m_phy[i]);
    for (int i = 4; i >= 0; i--) fr.push_back(m_rn[i]);
    fr.push_back(1'b1); fr.push_back(rd ? 1'b1 : 1'b0);
    for (int i = 15; i >= 0; i--) fr.push_back(rd ? 1'b1 : d[i]);
    if (rd) m_inv = 1;
  endtask

  // model step and per-clock comparison
  always @(posedge clk) begin
    bit was;
    int b;
    if (!rst_n) begin
      m_act = 0; m_rd = 0; m_cmd = 0; m_inv = 1; m_k = 0; m_h = 1;
      m_code = 4; m_stat = 0; m_rcv = 0; m_phy = 0; m_rn = 0;
    end else begin
      was = m_act;
      if (m_act) begin
        m_k++;
        if (m_rd && (m_k % (2*m_h)) == m_h && (m_k / (2*m_h)) >= 48)
          m_rcv = {m_rcv[14:0], mdio_i};
        if (m_k == 128*m_h) begin
          m_act = 0;
          if (m_rd) begin m_stat = m_rcv; m_inv = 0; end
        end
      end
      if (reg_wr) begin
        case (reg_addr)
          8'h20: begin
            m_code = int'(reg_wdata[3:0]);
            if (reg_wdata[31]) begin m_act = 0; m_cmd = 0; m_inv = 1; end
          end
          8'h24: begin
            if (reg_wdata[0] && !m_cmd && !was) begin m_rcv = 0; launch(1, 16'h0); end
            m_cmd = reg_wdata[0];
          end
          8'h28: begin m_phy = reg_wdata[12:8]; m_rn = reg_wdata[4:0]; end
          8'h2c: if (!was) launch(0, reg_wdata[15:0]);
          default: ;
        endcase
      end
    end
    #2;
    b = m_k / (2*m_h);
    chk("R5 mdc", {31'd0, mdc}, {31'd0, m_act && ((m_k % (2*m_h)) >= m_h)});
    chk("R6 mdio_oe", {31'd0, mdio_oe}, {31'd0, m_act && !(m_rd && b >= 46)});
    if (m_act && !(m_rd && b >= 46))
      chk("R4 mdio_o", {31'd0, mdio_o}, {31'd0, fr[b]});
    if (reg_addr == 8'h34) begin
      chk("R7 busy", {31'd0, reg_rdata[0]}, {31'd0, m_act});
      chk("R8 invalid", {31'd0, reg_rdata[2]}, {31'd0, m_inv});
    end
    if (reg_addr == 8'h30) chk("R6 status", reg_rdata, {16'd0, m_stat});
  end

  // PHY side: drive read data while the master listens
  always @(negedge clk) begin
    int b;
    b = m_k / (2*m_h);
    mdio_i <= (m_act && m_rd && b >= 48) ? phy_word[63-b] : 1'b1;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h34;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
    @(negedge clk);
    reg_addr = 8'h34;
  endtask

  task automatic wait_idle();
    while (m_act) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h34; reg_wdata = '0;
    mdio_i = 1'b1; phy_word = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 indicator", 8'h34, 32'h4);
    rd("R1 command", 8'h24, 32'h0);
    rd("R1 divider", 8'h20, 32'h4);
    rd("R1 status", 8'h30, 32'h0);
    chk("R1 mdc/oe", {30'd0, mdc, mdio_oe}, 32'h0);
    // R2 address and config readback
    wr(8'h28, 32'hFFFF_F5EA);
    rd("R2 address", 8'h28, 32'h0000_150A);
    wr(8'h20, 32'h0000_0001);
    rd("R2 divider", 8'h20, 32'h1);
    // R4 write frame, R9 second write while busy is ignored
    wr(8'h2c, 32'h0000_A5C3);
    repeat (20) @(negedge clk);
    wr(8'h2c, 32'h0000_1234);
    wait_idle();
    rd("R9 write data kept", 8'h2c, 32'h0000_A5C3);
    // R6 read frame
    phy_word = 16'h6B1E;
    wr(8'h24, 32'h0);
    wr(8'h24, 32'h1);
    wait_idle();
    rd("R6 read data", 8'h30, 32'h0000_6B1E);
    rd("R8 indicator after read", 8'h34, 32'h0);
    // R3 no rising edge, nothing starts
    wr(8'h24, 32'h1);
    @(negedge clk);
    chk("R3 no relaunch", {31'd0, reg_rdata[0]}, 32'h0);
    // fastest divider, R9 command edge during busy ignored
    wr(8'h20, 32'h0);
    wr(8'h28, 32'h0000_1F1F);
    phy_word = 16'h8001;
    wr(8'h24, 32'h0);
    wr(8'h24, 32'h1);
    repeat (10) @(negedge clk);
    wr(8'h24, 32'h0);
    wr(8'h24, 32'h1);
    wait_idle();
    rd("R6 read data fast", 8'h30, 32'h0000_8001);
    rd("R9 indicator", 8'h34, 32'h0);
    // R10 soft reset mid-frame
    wr(8'h20, 32'h2);
    wr(8'h2c, 32'h0000_0F0F);
    repeat (40) @(negedge clk);
    wr(8'h20, 32'h8000_0002);
    chk("R10 pins", {30'd0, mdc, mdio_oe}, 32'h0);
    rd("R10 indicator", 8'h34, 32'h4);
    rd("R10 command", 8'h24, 32'h0);
    rd("R2 reset bit reads 0", 8'h20, 32'h2);
    // R5 default-ratio write frame
    wr(8'h20, 32'h4);
    wr(8'h2c, 32'h0000_FFFF);
    wait_idle();
    rd("R7 idle after frame", 8'h34, 32'h4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule